// File: doc/BRIEF.md
# Write-Zero-to-Clear Interrupt Aggregator

This block collects single-cycle event pulses from the sources inside a storage host controller. Each pulse sets a sticky bit in a status register. Software reads that register to find which sources fired. It acknowledges a source by writing a word in which that source's bit is 0 and every other bit is 1. A written 0 clears a bit and a written 1 keeps it, so a plain write of zero acknowledges everything.

A mask register sits beside the status register. In the mask, a 1 blocks the matching source from the interrupt line. A separate enable register holds one gate bit. The single interrupt output is a level signal. It is high when the gate bit is set and at least one unmasked status bit is pending. It is registered, so it follows the register state one cycle later.

The `GEN` parameter chooses the number of sources. The first generation has 11 sources and later generations have 12. Mask bits above the source count always read 1 and cannot be changed. Status bits above the source count always read 0.

Top module: `wzc_irq_agg`

## Requirements
- R1: After reset the status register reads 0x00000000, the mask register reads 0xFFFFFFFF (every source masked), the enable register reads 0 and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[i]` sets status bit i at the next clock edge. The bit stays set after the pulse ends, until software clears it.
- R3: A write to the status register (byte offset 0x1508) clears each bit whose written value is 0 and leaves each bit whose written value is 1 unchanged. Writing 0x00000000 clears every status bit.
- R4: If an event on source i arrives in the same cycle as a write that clears bit i, the bit ends up set.
- R5: A mask register bit (byte offset 0x150C) set to 1 stops the matching status bit from raising `irq_o`. Mask bit i is cleared to 0 to let source i through.
- R6: Bit 11 of the enable register (byte offset 0x1510) gates `irq_o`. While it is 0, `irq_o` stays low. The other bits of the enable register read 0 and ignore writes.
- R7: `irq_o` is registered. It equals enable AND (OR over i of status[i] AND NOT mask[i]), taken from the register values one clock earlier.
- R8: Mask bits at or above the source count read 1 and ignore writes. Status bits at or above the source count read 0.
- R9: The source count is 11 when `GEN` is 1 and 12 otherwise. The writable mask field is therefore 0x7FF or 0xFFF.
- R10: A read from any offset other than the three register offsets returns 0. Writes are decoded on the full `reg_addr` value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Event pulses, one per source, active high |
| reg_addr | input | ADDR_W | Byte offset for register reads and writes |
| reg_wr | input | 1 | Write strobe for the register at `reg_addr` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Registered, level-sensitive interrupt output |

## Verification
The bench sweeps every source, once masked and once unmasked, and checks both that the status bit is sticky and that `irq_o` is high only where expected. A design that clears on written 1s, or that treats the mask as active-low, fails this sweep.

The collision case drives an event on a source in the same cycle as an all-zero write. A design that lets the clear win loses that event.

The bench samples `irq_o` one cycle after the enable bit drops and again one cycle later. This catches an output that is combinational instead of registered, and an output that ignores the gate bit.

A second instance built with `GEN` = 1 shows that mask bit 11 is stuck at 1 and that status never reports a twelfth source. A design with the width mixed up between generations fails these checks.

// File: rtl/wzc_irq_pkg.sv
package wzc_irq_pkg;

  localparam int REG_W = 32;

  // Number of event sources for a given generation.
  function automatic int src_count(input int gen);
    return (gen <= 1) ? 11 : 12;
  endfunction

  // Force every bit at or above n to 1; keep the bits below n.
  function automatic logic [REG_W-1:0] pad_mask(input logic [REG_W-1:0] w, input int n);
    logic [REG_W-1:0] r;
    for (int i = 0; i < REG_W; i++) begin
      r[i] = (i >= n) ? 1'b1 : w[i];
    end
    return r;
  endfunction

  // Writable field of the mask for n sources.
  function automatic logic [REG_W-1:0] field_bits(input int n);
    logic [REG_W-1:0] r;
    for (int i = 0; i < REG_W; i++) begin
      r[i] = (i < n);
    end
    return r;
  endfunction

endpackage

// File: rtl/wzc_irq_status.sv
module wzc_irq_status #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         wr_stat,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] stat_q
);

  // Bits being acknowledged this cycle, and bits being set this cycle.
  logic [N-1:0] clr_vec;
  logic [N-1:0] set_vec;

  assign clr_vec = wr_stat ? (~wdata & stat_q) : '0;
  assign set_vec = evt;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[g] <= 1'b0;
      end else if (set_vec[g]) begin
        stat_q[g] <= 1'b1;   // set wins over any clear
      end else if (clr_vec[g]) begin
        stat_q[g] <= 1'b0;
      end
    end
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_zero_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & ~$past(wdata) & ~$past(evt)) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/wzc_irq_mask.sv
module wzc_irq_mask #(
  parameter int N = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_mask,
  input  logic [31:0] wdata,
  output logic [31:0] mask_q,
  output logic [N-1:0] mask_src
);

  logic [31:0] mask_d;

  assign mask_d   = wzc_irq_pkg::pad_mask(wdata, N);
  assign mask_src = mask_q[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (wr_mask) begin
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/wzc_irq_gate.sv
module wzc_irq_gate #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wbit,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] mask,
  output logic         en_q,
  output logic         irq_q
);

  logic [N-1:0] pending;
  logic         any_pending;

  assign pending     = stat & ~mask;
  assign any_pending = |pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (wr_en) en_q <= wbit;
      irq_q <= en_q & any_pending;
    end
  end

  assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_q);

  assert_all_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |=> !irq_q);

endmodule

// File: rtl/wzc_irq_agg.sv
module wzc_irq_agg #(
  parameter int GEN      = 2,
  parameter int ADDR_W   = 13,
  parameter int STAT_OFS = 13'h1508,
  parameter int MASK_OFS = 13'h150C,
  parameter int ENA_OFS  = 13'h1510,
  parameter int EN_BIT   = 11,
  localparam int NUM_SRC = wzc_irq_pkg::src_count(GEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_o
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ENA_OFS);

  logic               hit_stat, hit_mask, hit_ena;
  logic [NUM_SRC-1:0] stat_q;
  logic [31:0]        mask_q;
  logic [NUM_SRC-1:0] mask_src;
  logic               en_q;

  assign hit_stat = (reg_addr == A_STAT);
  assign hit_mask = (reg_addr == A_MASK);
  assign hit_ena  = (reg_addr == A_ENA);

  wzc_irq_status #(.N(NUM_SRC)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_i),
    .wr_stat (reg_wr & hit_stat),
    .wdata   (reg_wdata[NUM_SRC-1:0]),
    .stat_q  (stat_q)
  );

  wzc_irq_mask #(.N(NUM_SRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mask  (reg_wr & hit_mask),
    .wdata    (reg_wdata),
    .mask_q   (mask_q),
    .mask_src (mask_src)
  );

  wzc_irq_gate #(.N(NUM_SRC)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr & hit_ena),
    .wbit  (reg_wdata[EN_BIT]),
    .stat  (stat_q),
    .mask  (mask_src),
    .en_q  (en_q),
    .irq_q (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit_stat) begin
      reg_rdata[NUM_SRC-1:0] = stat_q;
    end else if (hit_mask) begin
      reg_rdata = mask_q;
    end else if (hit_ena) begin
      reg_rdata[EN_BIT] = en_q;
    end
  end

  assert_irq_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(en_q) && ($past(stat_q & ~mask_src) != '0));

endmodule

// File: tb/wzc_irq_agg_tb.sv
`timescale 1ns/1ps
module wzc_irq_agg_tb_top;

  localparam logic [12:0] A_STAT = 13'h1508;
  localparam logic [12:0] A_MASK = 13'h150C;
  localparam logic [12:0] A_ENA  = 13'h1510;
  localparam int N2 = 12;
  localparam int N1 = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt2 = '0;
  logic [10:0] evt1 = '0;
  logic [12:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd2, rd1;
  logic        irq2, irq1;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wzc_irq_agg #(.GEN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt2), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd2), .irq_o(irq2));

  wzc_irq_agg #(.GEN(1)) dut_g1_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt1), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd1), .irq_o(irq1));

  function automatic logic [31:0] fld(input int n);
    return (32'h1 << n) - 32'h1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [12:0] a,
                        input logic [31:0] e2, input logic [31:0] e1);
    reg_addr = a;
    #1;
    chk({req, " gen2"}, rd2, e2);
    chk({req, " gen1"}, rd1, e1);
  endtask

  task automatic pulse(input logic [11:0] v);
    evt2 = v; evt1 = v[10:0];
    step();
    evt2 = '0; evt1 = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd_chk("R1 status", A_STAT, 32'h0, 32'h0);
    rd_chk("R1 mask", A_MASK, 32'hFFFFFFFF, 32'hFFFFFFFF);
    rd_chk("R1 enable", A_ENA, 32'h0, 32'h0);
    chk("R1 irq gen2", {31'b0, irq2}, 32'h0);
    chk("R1 irq gen1", {31'b0, irq1}, 32'h0);

    // R10 unmapped offsets
    rd_chk("R10 unmapped", 13'h1504, 32'h0, 32'h0);
    rd_chk("R10 unmapped", 13'h150A, 32'h0, 32'h0);

    // R6 only bit 11 of the enable register exists
    wr(A_ENA, 32'hFFFFFFFF);
    rd_chk("R6 enable bits", A_ENA, 32'h800, 32'h800);

    // R2/R5/R7 sweep over every source, masked and unmasked
    for (int i = 0; i < N2; i++) begin
      for (int m = 0; m < 2; m++) begin
        logic [31:0] mw;
        mw = (m != 0) ? 32'hFFFFFFFF : ~(32'h1 << i);
        wr(A_MASK, mw);
        wr(A_STAT, 32'h0);
        pulse(12'(1 << i));
        rd_chk("R2 set", A_STAT, 32'h1 << i, (32'h1 << i) & fld(N1));
        chk("R7 irq lags", {31'b0, irq2}, 32'h0);
        step();
        rd_chk("R2 sticky", A_STAT, 32'h1 << i, (32'h1 << i) & fld(N1));
        chk("R5 mask gen2", {31'b0, irq2}, (m == 0) ? 32'h1 : 32'h0);
        chk("R5 mask gen1", {31'b0, irq1}, (m == 0 && i < N1) ? 32'h1 : 32'h0);
      end
    end

    // R6/R7 enable gating, one-cycle latency
    wr(A_MASK, 32'h0);
    wr(A_STAT, 32'h0);
    pulse(12'h008);
    step();
    chk("R6 irq on", {31'b0, irq2}, 32'h1);
    wr(A_ENA, 32'h0);
    chk("R7 irq after gate write", {31'b0, irq2}, 32'h1);
    step();
    chk("R6 irq gated", {31'b0, irq2}, 32'h0);
    chk("R6 irq gated gen1", {31'b0, irq1}, 32'h0);
    wr(A_ENA, 32'hFFFFF7FF);
    rd_chk("R6 other bits ignored", A_ENA, 32'h0, 32'h0);
    step();
    chk("R6 still gated", {31'b0, irq2}, 32'h0);

    // R3 write-zero-to-clear with several patterns
    begin
      logic [31:0] pats [5];
      pats[0] = 32'hFFFFFFFF; pats[1] = 32'hAAAAAAAA; pats[2] = 32'h55555555;
      pats[3] = 32'h00000F0F; pats[4] = 32'h00000000;
      for (int k = 0; k < 5; k++) begin
        pulse(12'hFFF);
        wr(A_STAT, pats[k]);
        rd_chk("R3 ack", A_STAT, pats[k] & fld(N2), pats[k] & fld(N1));
      end
    end

    // R4 set wins over a same-cycle clear
    pulse(12'hFFF);
    evt2 = 12'h020; evt1 = 11'h020;
    wr(A_STAT, 32'h0);
    evt2 = '0; evt1 = '0;
    rd_chk("R4 set wins", A_STAT, 32'h20, 32'h20);

    // R8/R9 width of the mask and status by generation
    wr(A_MASK, 32'h0);
    rd_chk("R8 R9 mask upper", A_MASK, ~fld(N2), ~fld(N1));
    wr(A_MASK, 32'h12345E78);
    rd_chk("R8 R9 mask pattern", A_MASK,
           32'h12345E78 | ~fld(N2), 32'h12345E78 | ~fld(N1));
    wr(A_STAT, 32'h0);
    pulse(12'hFFF);
    rd_chk("R8 R9 status width", A_STAT, fld(N2), fld(N1));

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule